// File: doc/BRIEF.md
# Sanity and Bus Timeout Monitor

This block watches for two kinds of system hang with two independent down counters. The first is a software watchdog. It counts down on a slow enable strobe, and software restarts it by writing a new start value before it runs out. A power-off request also starts it. The second times bus cycles that are waiting for a response. It counts on a fast enable strobe, but only while the arbiter acknowledge is active. Whenever the acknowledge is inactive, the counter is held at its start value.

Both counters feed one shared error bit. When either counter runs out, the error bit is set, the interrupt line and the diagnostic indicator come on, and a flag for that counter is latched. Software reads the flags to tell the two sources apart. If the bus counter ran out, a one-cycle fault pulse also goes to the memory and arbiter logic. One write strobe clears the error bit and both flags, and it acts only when it carries the clear address.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tmo_monitor`

## Requirements
- R1: While the watchdog counter is running, it decreases by one on each clock in which `tick_slow` is high, and it holds its value otherwise. After reset it reads 0 and stays idle until it is started.
- R2: A high `san_kick` loads `san_load` into the watchdog counter and starts it. A kick wins over a `tick_slow` in the same cycle, so the counter reads `san_load` after that edge.
- R3: A rising edge of `pwr_off_req` starts the watchdog counter in the same way as a kick. Holding `pwr_off_req` high does not load the counter again.
- R4: In every cycle with `arb_ack` low, the bus counter is loaded with `BUS_LOAD` and re-armed. While `arb_ack` is high, it decreases by one on each clock in which `tick_fast` is high.
- R5: A running counter runs out when it is ticked while it reads 1 or 0. It then reads 0 and stays at 0. The watchdog counter stays there until its next start, and the bus counter until `arb_ack` goes low.
- R6: `err_bit` goes high at the clock edge where either counter reaches 0 by running out. `irq15` and `diag_led` always equal `err_bit`.
- R7: `status[0]` (watchdog) and `status[1]` (bus) are sticky flags. Each is set at the edge where its own counter runs out.
- R8: A cycle with `clr_wr` high and `clr_addr` equal to `CLR_ADDR` clears `err_bit` and both flags at the next edge. A write to any other address has no effect. If a counter runs out in the same cycle as a clear, the set wins for `err_bit` and for that counter's flag.
- R9: `bus_tmo` is high for exactly one cycle. That cycle begins at the edge where the bus counter runs out, and `status[1]` is high during it.
- R10: Reset gives `san_count`=0, `bus_count`=`BUS_LOAD`, `err_bit`=0, `status`=0 and `bus_tmo`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_slow | input | 1 | Count enable for the watchdog counter |
| tick_fast | input | 1 | Count enable for the bus counter |
| san_kick | input | 1 | Software restart strobe for the watchdog counter |
| san_load | input | SAN_W | Start value for the watchdog counter |
| pwr_off_req | input | 1 | Power-off request; its rising edge starts the watchdog |
| arb_ack | input | 1 | Arbiter acknowledge; when low, the bus counter is held loaded |
| clr_wr | input | 1 | Clear write strobe |
| clr_addr | input | AW | Address of the clear write |
| san_count | output | SAN_W | Current watchdog counter value |
| bus_count | output | BUS_W | Current bus counter value |
| status | output | 2 | Sticky flags: bit 0 watchdog, bit 1 bus |
| err_bit | output | 1 | Shared timeout error bit |
| irq15 | output | 1 | Level-15 interrupt request |
| diag_led | output | 1 | Diagnostic indicator drive |
| bus_tmo | output | 1 | One-cycle bus fault pulse |

## Verification
The assertions check, on every cycle, the rules that hold from one edge to the next:
- a counter that is not ticked or not running keeps its value;
- a counter that runs out lands at 0;
- the error bit stays sticky until a matching clear, and a clear with no expiry in the same cycle empties it;
- the bus fault pulse lasts one cycle and comes with the bus flag.

Some behaviour only the bench scenarios can show:
- start values are honoured, and a kick beats a tick in the same cycle;
- a held power-off request does not load the counter again;
- a set beats a clear in the same cycle;
- a clear at a wrong address is ignored.

The bench shows these by comparing every output each cycle with a behavioural model, under both directed and random stimulus.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  // Sticky per-source expiry flags, bus in the upper bit
  typedef struct packed {
    logic bus;
    logic san;
  } tmo_flags_t;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/tmo_countdown.sv
module tmo_countdown #(
  parameter int unsigned    W         = 16,
  parameter logic [W-1:0]   RST_VAL   = '0,
  parameter bit             RST_ARMED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         fire
);

  localparam logic [W-1:0] ONE = W'(1);

  logic armed;

  // Expiry: a running counter is ticked at 1 or 0 with no restart pending
  always_comb fire = armed && !restart && tick && (count <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= RST_VAL;
      armed <= RST_ARMED;
    end else if (restart) begin
      count <= load_val;
      armed <= 1'b1;
    end else if (armed && tick) begin
      if (count <= ONE) begin
        count <= '0;
        armed <= 1'b0;
      end else begin
        count <= count - ONE;
      end
    end
  end

  // R1: no tick and no restart -> value held
  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(count));

  // R5: after running out, the counter parks until restarted
  p_park_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !restart) |=> $stable(count));

  // R5: the expiry edge lands at zero
  p_fire_lands_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (count == '0));

endmodule

// File: rtl/tmo_err_latch.sv
module tmo_err_latch
  import tmo_pkg::*;
#(
  parameter int unsigned    AW       = 32,
  parameter logic [AW-1:0]  CLR_ADDR = AW'(32'h0004_4000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          san_fire,
  input  logic          bus_fire,
  input  logic          clr_wr,
  input  logic [AW-1:0] clr_addr,
  output logic          err_q,
  output tmo_flags_t    flags_q
);

  logic clr_hit;
  logic any_fire;

  always_comb begin
    clr_hit  = clr_wr && (clr_addr == CLR_ADDR);
    any_fire = san_fire || bus_fire;
  end

  // A set always wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      if (san_fire)     flags_q.san <= 1'b1;
      else if (clr_hit) flags_q.san <= 1'b0;

      if (bus_fire)     flags_q.bus <= 1'b1;
      else if (clr_hit) flags_q.bus <= 1'b0;

      if (any_fire)     err_q <= 1'b1;
      else if (clr_hit) err_q <= 1'b0;
    end
  end

  // R6: any expiry sets the shared error bit
  p_set_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire |=> err_q);

  // R7: the error bit stays set until a matching clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_hit) |=> err_q);

  // R8: a clear with no expiry empties the error bit and both flags
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !any_fire) |=> (!err_q && flags_q == '0));

endmodule

// File: rtl/tmo_monitor.sv
module tmo_monitor
  import tmo_pkg::*;
#(
  parameter int unsigned       SAN_W    = 16,
  parameter int unsigned       BUS_W    = 16,
  parameter logic [BUS_W-1:0]  BUS_LOAD = BUS_W'(200),
  parameter int unsigned       AW       = 32,
  parameter logic [AW-1:0]     CLR_ADDR = AW'(32'h0004_4000)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             san_kick,
  input  logic [SAN_W-1:0] san_load,
  input  logic             pwr_off_req,
  input  logic             arb_ack,
  input  logic             clr_wr,
  input  logic [AW-1:0]    clr_addr,
  output logic [SAN_W-1:0] san_count,
  output logic [BUS_W-1:0] bus_count,
  output logic [NUM_SRC-1:0] status,
  output logic             err_bit,
  output logic             irq15,
  output logic             diag_led,
  output logic             bus_tmo
);

  logic       pwr_q;
  logic       pwr_rise;
  logic       san_restart;
  logic       bus_restart;
  logic       san_fire;
  logic       bus_fire;
  logic       bus_tmo_q;
  logic       err_q;
  tmo_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q     <= 1'b0;
      bus_tmo_q <= 1'b0;
    end else begin
      pwr_q     <= pwr_off_req;
      bus_tmo_q <= bus_fire;
    end
  end

  always_comb begin
    pwr_rise    = pwr_off_req && !pwr_q;
    san_restart = san_kick || pwr_rise;
    bus_restart = !arb_ack;
  end

  tmo_countdown #(
    .W(SAN_W), .RST_VAL('0), .RST_ARMED(1'b0)
  ) u_san_cnt (
    .clk(clk), .rst_n(rst_n), .restart(san_restart), .load_val(san_load),
    .tick(tick_slow), .count(san_count), .fire(san_fire)
  );

  tmo_countdown #(
    .W(BUS_W), .RST_VAL(BUS_LOAD), .RST_ARMED(1'b1)
  ) u_bus_cnt (
    .clk(clk), .rst_n(rst_n), .restart(bus_restart), .load_val(BUS_LOAD),
    .tick(tick_fast), .count(bus_count), .fire(bus_fire)
  );

  tmo_err_latch #(
    .AW(AW), .CLR_ADDR(CLR_ADDR)
  ) u_err (
    .clk(clk), .rst_n(rst_n), .san_fire(san_fire), .bus_fire(bus_fire),
    .clr_wr(clr_wr), .clr_addr(clr_addr), .err_q(err_q), .flags_q(flags_q)
  );

  assign status   = {flags_q.bus, flags_q.san};
  assign err_bit  = err_q;
  assign irq15    = err_q;
  assign diag_led = err_q;
  assign bus_tmo  = bus_tmo_q;

  // R9: the fault pulse is a single cycle
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tmo_q |=> !bus_tmo_q);

  // R9: the fault pulse comes with the bus flag
  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tmo_q |-> flags_q.bus);

  // R4: with acknowledge low, the bus counter is back at its start value
  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_ack |=> (bus_count == BUS_LOAD));

endmodule

// File: tb/tmo_monitor_tb.sv
module tmo_monitor_tb;

  localparam int unsigned SAN_W = 16;
  localparam int unsigned BUS_W = 8;
  localparam int          BLOAD = 6;
  localparam int unsigned AW    = 32;
  localparam logic [AW-1:0] CLR = 32'h0004_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_slow = 0, tick_fast = 0, san_kick = 0, pwr_off_req = 0;
  logic arb_ack = 0, clr_wr = 0;
  logic [SAN_W-1:0] san_load = '0;
  logic [AW-1:0] clr_addr = '0;
  logic [SAN_W-1:0] san_count;
  logic [BUS_W-1:0] bus_count;
  logic [1:0] status;
  logic err_bit, irq15, diag_led, bus_tmo;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tmo_monitor #(
    .SAN_W(SAN_W), .BUS_W(BUS_W), .BUS_LOAD(BUS_W'(BLOAD)), .AW(AW), .CLR_ADDR(CLR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .san_kick(san_kick), .san_load(san_load), .pwr_off_req(pwr_off_req),
    .arb_ack(arb_ack), .clr_wr(clr_wr), .clr_addr(clr_addr),
    .san_count(san_count), .bus_count(bus_count), .status(status),
    .err_bit(err_bit), .irq15(irq15), .diag_led(diag_led), .bus_tmo(bus_tmo)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_san, m_bus;
  bit m_san_run, m_bus_run, m_err, m_fs, m_fb, m_pulse, m_pwr_prev;
  bit started = 0;

  always @(posedge clk) begin
    bit sf, bf, clr;
    started = 1;
    if (!rst_n) begin
      m_san = 0; m_san_run = 0; m_bus = BLOAD; m_bus_run = 1;
      m_err = 0; m_fs = 0; m_fb = 0; m_pulse = 0; m_pwr_prev = 0;
    end else begin
      sf = 0; bf = 0;
      clr = clr_wr && (clr_addr == CLR);
      if (san_kick || (pwr_off_req && !m_pwr_prev)) begin
        m_san = int'(san_load); m_san_run = 1;
      end else if (m_san_run && tick_slow) begin
        if (m_san <= 1) begin m_san = 0; m_san_run = 0; sf = 1; end
        else m_san = m_san - 1;
      end
      if (!arb_ack) begin
        m_bus = BLOAD; m_bus_run = 1;
      end else if (m_bus_run && tick_fast) begin
        if (m_bus <= 1) begin m_bus = 0; m_bus_run = 0; bf = 1; end
        else m_bus = m_bus - 1;
      end
      if (sf) m_fs = 1; else if (clr) m_fs = 0;
      if (bf) m_fb = 1; else if (clr) m_fb = 0;
      if (sf || bf) m_err = 1; else if (clr) m_err = 0;
      m_pulse = bf;
      m_pwr_prev = pwr_off_req;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R1", "san_count", san_count, m_san);
      chk("R4", "bus_count", bus_count, m_bus);
      chk("R6", "err_bit", err_bit, m_err);
      chk("R6", "irq15", irq15, m_err);
      chk("R6", "diag_led", diag_led, m_err);
      chk("R7", "status", status, {m_fb, m_fs});
      chk("R9", "bus_tmo", bus_tmo, m_pulse);
    end
  end

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic do_clear();
    clr_wr = 1; clr_addr = CLR;
    step();
    clr_wr = 0;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer than 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    // R10: reset state
    chk("R10", "san_count", san_count, 0);
    chk("R10", "bus_count", bus_count, BLOAD);
    chk("R10", "err_bit", err_bit, 0);
    chk("R10", "status", status, 0);
    chk("R10", "bus_tmo", bus_tmo, 0);
    rst_n = 1;
    step();

    // R2: kick beats tick
    san_load = 5; san_kick = 1; tick_slow = 1;
    step();
    chk("R2", "san_count after kick", san_count, 5);
    san_kick = 0;
    for (int i = 0; i < 4; i++) step();
    chk("R1", "san_count after 4 ticks", san_count, 1);
    step();
    chk("R5", "san_count at expiry", san_count, 0);
    chk("R6", "err_bit on sanity expiry", err_bit, 1);
    chk("R6", "diag_led on sanity expiry", diag_led, 1);
    chk("R7", "status sanity flag", status, 1);
    for (int i = 0; i < 3; i++) step();
    chk("R5", "san_count parked", san_count, 0);
    tick_slow = 0;

    // R8: wrong address ignored, right address clears
    clr_wr = 1; clr_addr = CLR + 4;
    step();
    chk("R8", "err_bit after wrong-address clear", err_bit, 1);
    chk("R8", "status after wrong-address clear", status, 1);
    clr_addr = CLR;
    step();
    clr_wr = 0;
    chk("R8", "err_bit after clear", err_bit, 0);
    chk("R8", "status after clear", status, 0);

    // R3: power-off edge starts, held level does not reload
    san_load = 3; pwr_off_req = 1;
    step();
    chk("R3", "san_count after power-off edge", san_count, 3);
    tick_slow = 1;
    step();
    chk("R3", "san_count with power-off held", san_count, 2);
    step(); step();
    chk("R3", "san_count expired", san_count, 0);
    chk("R6", "err_bit power-off expiry", err_bit, 1);
    pwr_off_req = 0; tick_slow = 0;
    do_clear();

    // R4, R9: bus counter
    arb_ack = 0;
    step();
    chk("R4", "bus_count held", bus_count, BLOAD);
    arb_ack = 1; tick_fast = 1;
    for (int i = 0; i < BLOAD - 1; i++) step();
    chk("R4", "bus_count counted", bus_count, 1);
    step();
    chk("R9", "bus_tmo pulse", bus_tmo, 1);
    chk("R7", "status bus flag", status, 2);
    step();
    chk("R9", "bus_tmo single cycle", bus_tmo, 0);
    chk("R5", "bus_count parked", bus_count, 0);
    tick_fast = 0; arb_ack = 0;
    step();
    chk("R4", "bus_count reloaded", bus_count, BLOAD);
    do_clear();

    // R8: set wins over clear in the same cycle
    arb_ack = 1; tick_fast = 1;
    for (int i = 0; i < BLOAD - 1; i++) step();
    clr_wr = 1; clr_addr = CLR;
    step();
    clr_wr = 0;
    chk("R8", "err_bit set beats clear", err_bit, 1);
    chk("R8", "status set beats clear", status, 2);
    tick_fast = 0; arb_ack = 0;
    do_clear();

    // Random phase, model-compared each cycle
    for (int i = 0; i < 4000; i++) begin
      tick_slow = (($urandom % 4) == 0);
      tick_fast = (($urandom % 2) == 0);
      san_kick  = (($urandom % 40) == 0);
      san_load  = SAN_W'($urandom % 12);
      if (($urandom % 50) == 0) pwr_off_req = ~pwr_off_req;
      if (($urandom % 10) == 0) arb_ack = ~arb_ack;
      clr_wr    = (($urandom % 30) == 0);
      clr_addr  = (($urandom % 2) == 0) ? CLR : (CLR ^ 32'h10);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule